// File: doc/BRIEF.md
# Multicycle Multiply/Divide Sequencer

This block runs the execute phase of 16-bit unsigned multiply and divide instructions on a processor built around a single 16-bit internal bus and a file of eight 16-bit general registers. Once the fetch steps have finished, the instruction decoder presents the destination and source register fields and the operation select, and pulses a strobe. The block then reads its operands and writes its results through the register-file ports, one transfer per clock cycle. It holds the operands and the 32-bit result in its own buffer registers in between.

Register 0 has a fixed role. A divide takes the upper word of its 32-bit dividend from it, and it receives the remainder. A multiply writes the upper word of its product to it. Because the bus is 16 bits wide, every 32-bit result leaves the block in two separate write cycles. A divide by zero and a quotient too wide for 16 bits each raise a flag. The flag stays set until the next accepted instruction.

Top module: `muldiv_seq`

## Requirements
- R1: After reset the block is idle. busy, done, rd_en, wr_en, div_zero and div_ovf are all 0.
- R2: The strobe is taken only while busy is 0. Once it is taken, busy is 1 from the next cycle through the cycle in which done is 1. A strobe that arrives while busy is 1 has no effect on the transfers or the results.
- R3: op_div=0 selects multiply. The block reads R[rb], then R[rc]. It then writes the upper 16 bits of the unsigned 32-bit product to register 0, and then the lower 16 bits to R[ra]. done is 1 in the cycle of the final write, 4 cycles after the edge that took the strobe.
- R4: op_div=1 selects divide. The block reads R[rb] as the low dividend word, then register 0 as the high dividend word, then R[rc] as the divisor. It then writes the quotient to R[ra], and then the remainder to register 0. done is 1 in the cycle of the final write, 5 cycles after the edge that took the strobe.
- R5: Both operations treat all operands as unsigned. For example, 0xFFFF times 0xFFFF gives 0xFFFE0001.
- R6: A divide by a zero divisor writes 0xFFFF as the quotient and the low dividend word as the remainder, and sets div_zero to 1.
- R7: When the quotient exceeds 16 bits, only its low 16 bits are written and div_ovf is set to 1. The remainder is still the exact remainder.
- R8: rd_en and wr_en are never 1 in the same cycle. Each instruction makes exactly two write cycles, and these are consecutive.
- R9: div_zero and div_ovf keep their value until the next accepted strobe. An accepted strobe clears both. A multiply never sets either flag.
- R10: When ra is 0, the later write decides what register 0 holds. After a multiply, register 0 holds the low product word. After a divide, it holds the remainder.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Strobe from the decoder: execute one instruction |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| ra | input | 3 | Destination register field |
| rb | input | 3 | First source register field |
| rc | input | 3 | Second source register field |
| rd_en | output | 1 | Register-file read this cycle |
| rd_addr | output | 3 | Register-file read address |
| rd_data | input | 16 | Combinational register-file read data |
| wr_en | output | 1 | Register-file write this cycle |
| wr_addr | output | 3 | Register-file write address |
| wr_data | output | 16 | Register-file write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final write of the instruction is on the bus |
| div_zero | output | 1 | Last divide had a zero divisor |
| div_ovf | output | 1 | Last divide produced a quotient wider than 16 bits |

## Verification
A wrong step state or a wrong operation latch shows up at the ports within a few cycles of the strobe. It appears as a write to the wrong register, a write in the wrong cycle, or done arriving too early or too late. The scoreboard compares every write address and value in order, so such an error is caught at the first bad write. A buffer register loaded in the wrong step, for example a high dividend word taken from the wrong register, shows up only in the data of the two result writes. For that reason the stimulus uses operand values that differ between registers, and it includes ra=0, a zero divisor, a quotient wider than 16 bits, and a strobe issued while busy.

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    op_div,
  input  logic [$clog2(NREG)-1:0] ra,
  input  logic [$clog2(NREG)-1:0] rb,
  input  logic [$clog2(NREG)-1:0] rc,
  output logic                    rd_en,
  output logic [$clog2(NREG)-1:0] rd_addr,
  input  logic [DW-1:0]           rd_data,
  output logic                    wr_en,
  output logic [$clog2(NREG)-1:0] wr_addr,
  output logic [DW-1:0]           wr_data,
  output logic                    busy,
  output logic                    done,
  output logic                    div_zero,
  output logic                    div_ovf
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] HI_REG = '0;

  typedef enum logic [2:0] {S_IDLE, S_T3, S_T4, S_T5, S_T6, S_T7} step_t;
  step_t st;

  logic          div_q;
  logic [AW-1:0] ra_q, rb_q, rc_q;
  logic [DW-1:0] a_buf, ah_buf, c_buf, ch_buf;

  logic [2*DW-1:0] dividend, quot, rem, prod;
  assign dividend = {ah_buf, a_buf};
  assign quot     = (rd_data == '0) ? '1 : dividend / {{DW{1'b0}}, rd_data};
  assign rem      = (rd_data == '0) ? '0 : dividend % {{DW{1'b0}}, rd_data};
  assign prod     = {{DW{1'b0}}, a_buf} * {{DW{1'b0}}, rd_data};

  assign busy = (st != S_IDLE);

  always_comb begin
    rd_en   = 1'b0;
    rd_addr = '0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    done    = 1'b0;
    case (st)
      S_T3: begin
        rd_en   = 1'b1;
        rd_addr = rb_q;
      end
      S_T4: begin
        rd_en   = 1'b1;
        rd_addr = div_q ? HI_REG : rc_q;
      end
      S_T5: begin
        if (div_q) begin
          rd_en   = 1'b1;
          rd_addr = rc_q;
        end else begin
          wr_en   = 1'b1;
          wr_addr = HI_REG;
          wr_data = ch_buf;
        end
      end
      S_T6: begin
        wr_en   = 1'b1;
        wr_addr = ra_q;
        wr_data = c_buf;
        done    = !div_q;
      end
      S_T7: begin
        wr_en   = 1'b1;
        wr_addr = HI_REG;
        wr_data = ch_buf;
        done    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      div_q    <= 1'b0;
      ra_q     <= '0;
      rb_q     <= '0;
      rc_q     <= '0;
      a_buf    <= '0;
      ah_buf   <= '0;
      c_buf    <= '0;
      ch_buf   <= '0;
      div_zero <= 1'b0;
      div_ovf  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st       <= S_T3;
          div_q    <= op_div;
          ra_q     <= ra;
          rb_q     <= rb;
          rc_q     <= rc;
          div_zero <= 1'b0;
          div_ovf  <= 1'b0;
        end
        S_T3: begin
          a_buf <= rd_data;
          st    <= S_T4;
        end
        S_T4: begin
          if (div_q) ah_buf <= rd_data;
          else {ch_buf, c_buf} <= prod;
          st <= S_T5;
        end
        S_T5: begin
          if (div_q) begin
            if (rd_data == '0) begin
              c_buf    <= '1;
              ch_buf   <= a_buf;
              div_zero <= 1'b1;
            end else begin
              c_buf   <= quot[DW-1:0];
              ch_buf  <= rem[DW-1:0];
              div_ovf <= (quot[2*DW-1:DW] != '0);
            end
          end
          st <= S_T6;
        end
        S_T6: st <= div_q ? S_T7 : S_IDLE;
        S_T7: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_ONE_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R8
  AST_TWO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_en && $past(wr_en))); // R8
  AST_TAKE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R2
  AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(ra_q) && $stable(div_q))); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(div_zero && div_ovf)); // R6
  AST_MUL_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !div_q) |-> (!div_zero && !div_ovf)); // R9
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy); // R2
endmodule

// File: tb/test_muldiv_seq.sv
`timescale 1ns/1ps
module test_muldiv_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_div = 1'b0;
  logic [2:0] ra = '0, rb = '0, rc = '0;
  logic rd_en, wr_en, busy, done, div_zero, div_ovf;
  logic [2:0] rd_addr, wr_addr;
  logic [15:0] rd_data, wr_data;
  logic [15:0] regs [8];
  logic [18:0] expq [$];
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  muldiv_seq i_muldiv_seq (.clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
    .ra(ra), .rb(rb), .rc(rc), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done),
    .div_zero(div_zero), .div_ovf(div_ovf));

  assign rd_data = regs[rd_addr];
  always @(posedge clk) if (wr_en) regs[wr_addr] <= wr_data;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every write is compared with the next expected item
  always @(negedge clk) if (rst_n && wr_en) begin
    if (expq.size() == 0) check("R2 unexpected write", {13'd0, wr_addr, wr_data}, 32'hFFFFFFFF);
    else check("R3/R4 write", {13'd0, wr_addr, wr_data}, {13'd0, expq.pop_front()});
    check("R8 no read during write", {31'd0, rd_en}, 32'd0);
  end

  task automatic run_op(input logic d, input logic [2:0] a, input logic [2:0] b,
                        input logic [2:0] c, input bit spurious);
    logic [31:0] p, dvd, q, r;
    logic ez, eo;
    int n;
    ez = 0; eo = 0;
    if (!d) begin
      p = {16'd0, regs[b]} * {16'd0, regs[c]};
      expq.push_back({3'd0, p[31:16]});
      expq.push_back({a, p[15:0]});
    end else begin
      dvd = {regs[0], regs[b]};
      if (regs[c] == 0) begin
        q = 32'hFFFF; r = {16'd0, regs[b]}; ez = 1;
      end else begin
        q = dvd / {16'd0, regs[c]}; r = dvd % {16'd0, regs[c]}; eo = (q[31:16] != 0);
      end
      expq.push_back({a, q[15:0]});
      expq.push_back({3'd0, r[15:0]});
    end
    op_div = d; ra = a; rb = b; rc = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after strobe", {31'd0, busy}, 32'd1);
    n = 1;
    while (!done && n < 40) begin
      if (spurious && n == 1) begin
        op_div = ~d; ra = 3'd7; rb = 3'd6; rc = 3'd5; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(d ? "R4 latency" : "R3 latency", n, d ? 5 : 4);
    check("R6 div_zero", {31'd0, div_zero}, {31'd0, ez});
    check("R7 div_ovf", {31'd0, div_ovf}, {31'd0, eo});
    @(negedge clk);
    check("R2 idle after done", {31'd0, busy}, 32'd0);
    check("R9 flags held", {30'd0, div_zero, div_ovf}, {30'd0, ez, eo});
    check("R8 two writes", expq.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 16'h1111 * i[15:0];
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {26'd0, busy, done, rd_en, wr_en, div_zero, div_ovf}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    regs[1] = 16'h1234; regs[2] = 16'h5678;
    run_op(1'b0, 3'd3, 3'd1, 3'd2, 0);                     // R3
    check("R3 low word in ra", regs[3], 16'h0060);
    regs[4] = 16'hFFFF; regs[5] = 16'hFFFF;
    run_op(1'b0, 3'd6, 3'd4, 3'd5, 0);                     // R5
    check("R5 unsigned product high", regs[0], 16'hFFFE);
    regs[0] = 16'h0001; regs[1] = 16'h2345; regs[2] = 16'h0100;
    run_op(1'b1, 3'd3, 3'd1, 3'd2, 0);                     // R4
    check("R4 quotient", regs[3], 16'h0123);
    check("R4 remainder", regs[0], 16'h0045);
    regs[0] = 16'h0002; regs[7] = 16'h0000; regs[1] = 16'hABCD;
    run_op(1'b1, 3'd4, 3'd1, 3'd7, 0);                     // R6
    check("R6 remainder is low word", regs[0], 16'hABCD);
    check("R6 quotient all ones", regs[4], 16'hFFFF);
    regs[0] = 16'h0005; regs[1] = 16'h0007; regs[2] = 16'h0003;
    run_op(1'b1, 3'd5, 3'd1, 3'd2, 0);                     // R7
    run_op(1'b0, 3'd6, 3'd1, 3'd2, 0);                     // R9 mul clears flags
    regs[1] = 16'h0300; regs[2] = 16'h0101;
    run_op(1'b0, 3'd0, 3'd1, 3'd2, 0);                     // R10
    check("R10 mul ra=0 keeps low", regs[0], 16'h0300);
    regs[0] = 16'h0000; regs[1] = 16'h0064; regs[2] = 16'h0007;
    run_op(1'b1, 3'd0, 3'd1, 3'd2, 0);                     // R10
    check("R10 div ra=0 keeps remainder", regs[0], 16'h0002);
    regs[1] = 16'h0010; regs[2] = 16'h0020; regs[7] = 16'h7777;
    run_op(1'b0, 3'd3, 3'd1, 3'd2, 1);                     // R2 strobe while busy
    repeat (6) @(negedge clk);
    check("R2 spurious strobe left R7", regs[7], 16'h7777);
    check("R2 spurious strobe no restart", {31'd0, busy}, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule